// File: doc/BRIEF.md
# LED Pixel Transmit Front End

This block sits between a 32-bit register bus and the serial pixel engine of an addressable-LED controller. Software programs a control word (run bit, colour-order code, transfer length), two timing words for the serializer, a DMA control word and an interrupt enable word. It then fills a transmit queue of pixel words through a data port. The queued words leave on a valid/ready pixel stream while the run bit is set.

The block watches the queue fill level against a programmable trigger level. With DMA off it raises a sticky CPU-request event. With DMA on it asserts a DMA request line instead. When the serializer reports the end of a frame, the block clears the run bit and latches a transfer-finished event. A live fill count in the status word lets software top up the queue exactly. A write to a full queue is dropped and noted in a sticky overflow bit.

Top module: `ledtx_front`

## Requirements
- R1: After reset all stored registers read 0, the run bit is 0, and `irq_o`, `dma_req_o` and `pix_valid_o` are low.
- R2: Register offsets are 0x00 control, 0x04 bit timing, 0x0C gap timing, 0x14 data, 0x18 DMA control, 0x1C interrupt enable and 0x20 status. Only defined bits are stored: control mask 0x1FFF01C1, bit timing 0x07FF07FF, gap timing 0x1FFF03FF, DMA control 0x3F and interrupt enable 0x23. A read issued in one cycle returns its data on `rdata_o` in the next cycle.
- R3: Each write to 0x14 pushes one word into a 32-entry queue. Words leave in write order, and the status field at bits 15:10 holds the current fill count (0 to 32).
- R4: `pix_valid_o` is high only while control bit 0 (run) is 1 and the queue is not empty. `pix_data_o` is the oldest word, and a cycle with valid and `pix_ready_i` both high removes it.
- R5: A data write while the fill is 32 is dropped and sets status bit 2 (overflow). Writing 1 to that bit clears it.
- R6: With DMA control bit 5 at 0, status bit 1 (CPU request) is set in the cycle after the fill is at or below DMA control bits 4:0 (trigger). It stays set until a 1 is written to it while the condition no longer holds.
- R7: With DMA control bit 5 at 1, `dma_req_o` is high exactly while the fill is at or below the trigger, and status bit 1 is not newly set.
- R8: A pulse on `xfer_done_i` clears the run bit and sets status bit 0 (finished). Writing 1 to status bit 0 clears it.
- R9: `irq_o` is high when interrupt-enable bit 5 is set and either status bit 0 with enable bit 0, or status bit 1 with enable bit 1, is set.
- R10: `run_o`, `color_order_o` and `xfer_len_o` carry control bits 0, 8:6 and 28:16. `bit_timing_o` and `gap_timing_o` carry the stored timing words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after `rd_i` |
| pix_valid_o | output | 1 | Pixel word available |
| pix_data_o | output | 32 | Oldest queued pixel word |
| pix_ready_i | input | 1 | Serializer takes the pixel word |
| xfer_done_i | input | 1 | Serializer finished the frame (one-cycle pulse) |
| run_o | output | 1 | Run bit of the control word |
| xfer_len_o | output | 13 | Programmed frame length |
| color_order_o | output | 3 | Colour-order code |
| bit_timing_o | output | 32 | Stored bit timing word |
| gap_timing_o | output | 32 | Stored gap timing word |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The assertions assume that `xfer_done_i` is a single-cycle pulse and that `wr_i` and `rd_i` are never high in the same cycle. They also assume `pix_ready_i` carries meaning only while `pix_valid_o` is high. The stimulus drives every bus access as a one-cycle strobe on the falling clock edge, with the other strobe held low. It pulses `xfer_done_i` for exactly one cycle and raises `pix_ready_i` only while the run bit is set, so pops happen only through the valid/ready handshake.

// File: rtl/ledtx_pkg.sv
package ledtx_pkg;
  typedef logic [5:0] reg_addr_t;

  localparam reg_addr_t A_CTRL = 6'h00;
  localparam reg_addr_t A_BITT = 6'h04;
  localparam reg_addr_t A_GAPT = 6'h0C;
  localparam reg_addr_t A_DATA = 6'h14;
  localparam reg_addr_t A_DMA  = 6'h18;
  localparam reg_addr_t A_IEN  = 6'h1C;
  localparam reg_addr_t A_STAT = 6'h20;

  localparam logic [31:0] M_CTRL = 32'h1FFF_01C1;
  localparam logic [31:0] M_BITT = 32'h07FF_07FF;
  localparam logic [31:0] M_GAPT = 32'h1FFF_03FF;

  localparam int unsigned FILL_LSB = 10;

  typedef struct packed {
    logic gie;
    logic req_en;
    logic fin_en;
  } ien_t;
endpackage

// File: rtl/ledtx_fifo.sv
module ledtx_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/ledtx_evt.sv
module ledtx_evt
  import ledtx_pkg::*;
#(
  parameter int unsigned CW = 6,
  parameter int unsigned TW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] fill_i,
  input  logic [TW-1:0] trig_i,
  input  logic          dma_en_i,
  input  logic          fin_set_i,
  input  logic          ovf_set_i,
  input  logic [2:0]    clr_i,
  input  ien_t          ien_i,
  output logic          fin_o,
  output logic          req_o,
  output logic          ovf_o,
  output logic          irq_o,
  output logic          dma_req_o
);
  logic lvl_low;
  logic fin_q, req_q, ovf_q;

  assign lvl_low = (fill_i <= CW'(trig_i));

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q <= 1'b0;
      req_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      fin_q <= fin_set_i | (fin_q & ~clr_i[0]);
      req_q <= (~dma_en_i & lvl_low) | (req_q & ~clr_i[1]);
      ovf_q <= ovf_set_i | (ovf_q & ~clr_i[2]);
    end
  end

  assign fin_o     = fin_q;
  assign req_o     = req_q;
  assign ovf_o     = ovf_q;
  assign dma_req_o = dma_en_i & lvl_low;
  assign irq_o     = ien_i.gie & ((fin_q & ien_i.fin_en) | (req_q & ien_i.req_en));
endmodule

// File: rtl/ledtx_front.sv
module ledtx_front
  import ledtx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  localparam int unsigned TW = $clog2(FIFO_DEPTH),
  localparam int unsigned CW = TW + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        pix_valid_o,
  output logic [31:0] pix_data_o,
  input  logic        pix_ready_i,
  input  logic        xfer_done_i,
  output logic        run_o,
  output logic [12:0] xfer_len_o,
  output logic [2:0]  color_order_o,
  output logic [31:0] bit_timing_o,
  output logic [31:0] gap_timing_o,
  output logic        irq_o,
  output logic        dma_req_o
);
  logic [31:0]   ctrl_q, bitt_q, gapt_q, rdata_q, rd_mux;
  logic          dma_en_q;
  logic [TW-1:0] trig_q;
  ien_t          ien_q;
  logic          push, pop, full, empty;
  logic [CW-1:0] fill_lvl;
  logic [2:0]    clr;
  logic          st_fin, st_req, st_ovf;

  assign push = wr_i && (addr_i == A_DATA);
  assign pop  = pix_valid_o && pix_ready_i;
  assign clr  = (wr_i && addr_i == A_STAT) ? wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      bitt_q   <= '0;
      gapt_q   <= '0;
      dma_en_q <= 1'b0;
      trig_q   <= '0;
      ien_q    <= '0;
    end else begin
      if (wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i & M_CTRL;
      else if (xfer_done_i)         ctrl_q[0] <= 1'b0;
      if (wr_i && addr_i == A_BITT) bitt_q <= wdata_i & M_BITT;
      if (wr_i && addr_i == A_GAPT) gapt_q <= wdata_i & M_GAPT;
      if (wr_i && addr_i == A_DMA) begin
        dma_en_q <= wdata_i[5];
        trig_q   <= wdata_i[TW-1:0];
      end
      if (wr_i && addr_i == A_IEN) ien_q <= '{gie: wdata_i[5], req_en: wdata_i[1], fin_en: wdata_i[0]};
    end
  end

  ledtx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wdata_i),
    .pop_i   (pop),
    .rdata_o (pix_data_o),
    .count_o (fill_lvl),
    .full_o  (full),
    .empty_o (empty)
  );

  ledtx_evt #(.CW(CW), .TW(TW)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fill_i    (fill_lvl),
    .trig_i    (trig_q),
    .dma_en_i  (dma_en_q),
    .fin_set_i (xfer_done_i),
    .ovf_set_i (push & full),
    .clr_i     (clr),
    .ien_i     (ien_q),
    .fin_o     (st_fin),
    .req_o     (st_req),
    .ovf_o     (st_ovf),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_CTRL: rd_mux = ctrl_q;
      A_BITT: rd_mux = bitt_q;
      A_GAPT: rd_mux = gapt_q;
      A_DMA: begin
        rd_mux[5]      = dma_en_q;
        rd_mux[TW-1:0] = trig_q;
      end
      A_IEN: rd_mux = {26'b0, ien_q.gie, 3'b0, ien_q.req_en, ien_q.fin_en};
      A_STAT: begin
        rd_mux[2:0]           = {st_ovf, st_req, st_fin};
        rd_mux[FILL_LSB +: CW] = fill_lvl;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o       = rdata_q;
  assign pix_valid_o   = ctrl_q[0] & ~empty;
  assign run_o         = ctrl_q[0];
  assign xfer_len_o    = ctrl_q[28:16];
  assign color_order_o = ctrl_q[8:6];
  assign bit_timing_o  = bitt_q;
  assign gap_timing_o  = gapt_q;
endmodule

// File: rtl/ledtx_front_chk.sv
module ledtx_front_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [5:0]    addr_i,
  input logic          wr_i,
  input logic [31:0]   wdata_i,
  input logic          pix_valid_o,
  input logic          pix_ready_i,
  input logic          xfer_done_i,
  input logic          run_o,
  input logic          irq_o,
  input logic          dma_req_o,
  input logic [CW-1:0] fill_i,
  input logic          gie_i,
  input logic          dma_en_i
);
  logic data_wr, ctrl_set;
  assign data_wr  = wr_i && (addr_i == 6'h14);
  assign ctrl_set = wr_i && (addr_i == 6'h00) && wdata_i[0];

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CW'(DEPTH)); // R3
  AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && fill_i < CW'(DEPTH) && !(pix_valid_o && pix_ready_i) |=> fill_i == $past(fill_i) + 1'b1); // R3
  AST_VALID_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> run_o && fill_i != '0); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && fill_i == CW'(DEPTH) && !(pix_valid_o && pix_ready_i) |=> fill_i == CW'(DEPTH)); // R5
  AST_DMA_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> dma_en_i); // R7
  AST_DONE_STOPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i && !ctrl_set |=> !run_o); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o); // R9
endmodule

bind ledtx_front ledtx_front_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .pix_valid_o (pix_valid_o),
  .pix_ready_i (pix_ready_i),
  .xfer_done_i (xfer_done_i),
  .run_o       (run_o),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .fill_i      (fill_lvl),
  .gie_i       (ien_q.gie),
  .dma_en_i    (dma_en_q)
);

// File: tb/ledtx_front_tb_top.sv
module ledtx_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pix_valid, pix_ready = 1'b0, xfer_done = 1'b0;
  logic [31:0] pix_data, bit_timing, gap_timing;
  logic        run, irq, dma_req;
  logic [12:0] xfer_len;
  logic [2:0]  color_order;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ledtx_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pix_valid_o(pix_valid),
    .pix_data_o(pix_data), .pix_ready_i(pix_ready), .xfer_done_i(xfer_done),
    .run_o(run), .xfer_len_o(xfer_len), .color_order_o(color_order),
    .bit_timing_o(bit_timing), .gap_timing_o(gap_timing),
    .irq_o(irq), .dma_req_o(dma_req)
  );

  typedef struct packed {
    logic [5:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  // R2 write/readback vectors
  localparam vec_t VEC [6] = '{
    '{6'h00, 32'hFFFF_FFFE, 32'h1FFF_01C0},
    '{6'h04, 32'hFFFF_FFFF, 32'h07FF_07FF},
    '{6'h0C, 32'hFFFF_FFFF, 32'h1FFF_03FF},
    '{6'h18, 32'hFFFF_FFDF, 32'h0000_001F},
    '{6'h1C, 32'hFFFF_FFFF, 32'h0000_0023},
    '{6'h00, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] drain_exp(input int i);
    if (i < 4)       return 32'hA2 + i;
    else if (i == 4) return 32'hB0;
    else             return 32'hC0 + (i - 5);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    bus_rd(6'h00, d); check("R1 ctrl", d, 32'h0);
    bus_rd(6'h18, d); check("R1 dma ctrl", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 dma_req", {31'b0, dma_req}, 32'h0);
    check("R1 valid", {31'b0, pix_valid}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      bus_wr(VEC[i].a, VEC[i].w);
      bus_rd(VEC[i].a, d);
      check("R2 readback", d, VEC[i].e);
    end

    bus_wr(6'h00, 32'h0123_0140);
    check("R10 order", {29'b0, color_order}, 32'h5);
    check("R10 len", {19'b0, xfer_len}, 32'h123);
    check("R10 run", {31'b0, run}, 32'h0);
    check("R10 bit timing", bit_timing, 32'h07FF_07FF);
    check("R10 gap timing", gap_timing, 32'h1FFF_03FF);

    // interrupt gating: cpu request set (fill 0 <= 31, DMA off)
    check("R9 irq on", {31'b0, irq}, 32'h1);
    bus_wr(6'h1C, 32'h03);
    check("R9 gie off", {31'b0, irq}, 32'h0);
    bus_wr(6'h1C, 32'h21);
    check("R9 req not enabled", {31'b0, irq}, 32'h0);

    // cpu request and fill count
    bus_wr(6'h18, 32'h04);
    bus_rd(6'h20, d); check("R6 req set", d, 32'h0000_0002);
    for (int i = 0; i < 6; i++) bus_wr(6'h14, 32'hA0 + i);
    bus_wr(6'h20, 32'h2);
    bus_rd(6'h20, d); check("R6 R3 req cleared fill 6", d, 32'h0000_1800);

    // pixel stream
    check("R4 no valid without run", {31'b0, pix_valid}, 32'h0);
    bus_wr(6'h00, 32'h1);
    check("R4 valid", {31'b0, pix_valid}, 32'h1);
    check("R4 head", pix_data, 32'hA0);
    @(negedge clk); pix_ready = 1'b1;
    @(negedge clk); check("R4 after pop", pix_data, 32'hA1);
    @(negedge clk); pix_ready = 1'b0;
    check("R4 after 2 pops", pix_data, 32'hA2);
    bus_rd(6'h20, d); check("R6 req at trigger", d, 32'h0000_1002);

    // transfer finished
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    check("R8 run cleared", {31'b0, run}, 32'h0);
    check("R8 valid low", {31'b0, pix_valid}, 32'h0);
    check("R8 R9 irq", {31'b0, irq}, 32'h1);
    bus_wr(6'h20, 32'h1);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);
    bus_rd(6'h20, d); check("R8 fin cleared", d, 32'h0000_1002);

    // DMA request
    bus_wr(6'h18, 32'h24);
    check("R7 dma_req", {31'b0, dma_req}, 32'h1);
    bus_wr(6'h20, 32'h2);
    bus_rd(6'h20, d); check("R7 no cpu req", d, 32'h0000_1000);
    bus_wr(6'h14, 32'hB0);
    check("R7 dma_req off", {31'b0, dma_req}, 32'h0);
    bus_wr(6'h18, 32'h00);

    // overflow
    for (int i = 0; i < 27; i++) bus_wr(6'h14, 32'hC0 + i);
    bus_rd(6'h20, d); check("R3 full", d, 32'h0000_8000);
    bus_wr(6'h14, 32'hDEAD);
    bus_rd(6'h20, d); check("R5 overflow", d, 32'h0000_8004);
    bus_wr(6'h20, 32'h4);
    bus_rd(6'h20, d); check("R5 overflow cleared", d, 32'h0000_8000);

    // drain, order check
    bus_wr(6'h00, 32'h1);
    pix_ready = 1'b1;
    for (int i = 0; i < 32; i++) begin
      check("R3 order", pix_data, drain_exp(i));
      check("R4 valid drain", {31'b0, pix_valid}, 32'h1);
      @(negedge clk);
    end
    pix_ready = 1'b0;
    check("R4 empty", {31'b0, pix_valid}, 32'h0);
    bus_rd(6'h20, d); check("R3 R6 empty status", d, 32'h0000_0002);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule